// File: doc/BRIEF.md
# Asynchronous Strobe Register Bus Slave

This block connects an external processor to an internal register space over an asynchronous, strobe-driven parallel bus. The master opens the address path by pulling an active-low address strobe low and closes it by releasing the strobe. The slave keeps the address it saw at that release. The master then pulls an active-low data strobe low, with a read/write select held steady. The slave brings both strobes into its own clock through two-flop synchronizers and finds their edges on the synchronized copies.

When the data strobe falls, the block records the direction and, for a write, the value on the data pins. It then issues one register access through a plain request/ready port. The active-low acknowledge stays high until the register side answers, so the master waits as long as the access takes. For a read the block drives the returned byte onto the shared data pins, but only while the data strobe is low. It lets the acknowledge go high again once the synchronized data strobe returns high.

Top module: `strobe_bus_slave`

## Requirements
- R1: After reset the acknowledge output is high, the data pins are not driven by the slave and no register request is issued.
- R2: While the address strobe is low the address pins are followed. The address presented with a request is the value present when the address strobe rose. Changes on the address pins after that rise do not alter it.
- R3: The read/write select is taken when the data strobe falls: 1 means read (reg_wr = 0) and 0 means write (reg_wr = 1).
- R4: Each data strobe cycle produces exactly one request pulse, one clock wide, in the clock after the synchronized data strobe falls.
- R5: For a write, the byte on the data pins when the synchronized data strobe falls is presented on reg_wdata together with the request.
- R6: The acknowledge goes low in the clock after reg_ready is seen high, and never before. Any number of wait states is allowed.
- R7: After the data strobe rises, the acknowledge returns high within three clocks.
- R8: During a read the slave drives reg_rdata, as captured at ready, onto the data pins while the data strobe is low. Before the data strobe falls, after it rises, and during writes the pins are left to other drivers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_as_n | input | 1 | Address strobe, active low, asynchronous |
| bus_ds_n | input | 1 | Data strobe, active low, asynchronous |
| bus_rnw | input | 1 | Direction select, 1 = read, 0 = write |
| bus_addr | input | ADDR_W (15) | Address pins |
| bus_data | inout | DATA_W (8) | Shared bidirectional data pins |
| bus_ack_n | output | 1 | Transfer acknowledge, active low |
| reg_req | output | 1 | One-clock register access request |
| reg_wr | output | 1 | Access is a write when high |
| reg_addr | output | ADDR_W (15) | Register address |
| reg_wdata | output | DATA_W (8) | Write data |
| reg_rdata | input | DATA_W (8) | Read data, valid with reg_ready |
| reg_ready | input | 1 | Register side finished the access |

## Verification
The bench builds the block with its defaults: a 15-bit address, 8-bit data and two synchronizer stages. The full-width address lets it use the all-zeros and all-ones corners and random addresses across the whole space. Two stages fix the strobe-to-action latency that the acknowledge timing checks count against. The register-side responder answers either in the same clock as the request or after a chosen delay of up to 40 clocks, which covers zero-wait and long stretched cycles.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_WAIT = 2'd2,
    XS_ACK  = 2'd3
  } xfer_state_e;

  function automatic logic edge_fall(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  function automatic logic edge_rise(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction
endpackage

// File: rtl/sbs_strobe_sync.sv
module sbs_strobe_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_n,
  output logic [WIDTH-1:0] sync_n,
  output logic [WIDTH-1:0] fell,
  output logic [WIDTH-1:0] rose
);
  import sbs_pkg::*;

  for (genvar g = 0; g < WIDTH; g++) begin : g_chan
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        prev  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw_n[g]};
        prev  <= chain[STAGES-1];
      end
    end
    assign sync_n[g] = chain[STAGES-1];
    assign fell[g]   = edge_fall(prev, chain[STAGES-1]);
    assign rose[g]   = edge_rise(prev, chain[STAGES-1]);
  end
endmodule

// File: rtl/sbs_addr_latch.sv
module sbs_addr_latch #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_open,
  input  logic              as_close,
  input  logic [ADDR_W-1:0] addr_pins,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (as_open) addr_q <= addr_pins;
  end

  // R2: once the strobe has closed and stays closed, the held address is frozen
  a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_open && $past(!as_open) && !as_close) |=> $stable(addr_q));
endmodule

// File: rtl/sbs_xfer_fsm.sv
module sbs_xfer_fsm #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ds_low,
  input  logic              ds_fall,
  input  logic              ds_rise,
  input  logic              rnw_pin,
  input  logic [DATA_W-1:0] wdata_pins,
  input  logic              reg_ready,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_req,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rd_hold,
  output logic              drive_en,
  output logic              ack_n
);
  import sbs_pkg::*;

  xfer_state_e st, st_nx;
  logic        dir_read;
  logic        acc_done;
  logic        ack_on;

  assign acc_done = reg_ready && (st == XS_REQ || st == XS_WAIT);

  always_comb begin
    st_nx = st;
    unique case (st)
      XS_IDLE: if (ds_fall) st_nx = XS_REQ;
      XS_REQ:  st_nx = reg_ready ? XS_ACK : XS_WAIT;
      XS_WAIT: if (reg_ready) st_nx = XS_ACK;
      XS_ACK:  if (!ds_low) st_nx = XS_IDLE;
      default: st_nx = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= XS_IDLE;
      dir_read  <= 1'b1;
      reg_wdata <= '0;
      rd_hold   <= '0;
    end else begin
      st <= st_nx;
      if (st == XS_IDLE && ds_fall) begin
        dir_read  <= rnw_pin;
        reg_wdata <= wdata_pins;
      end
      if (acc_done && dir_read) rd_hold <= reg_rdata;
    end
  end

  assign reg_req  = (st == XS_REQ);
  assign reg_wr   = ~dir_read;
  assign ack_on   = (st == XS_ACK) && ds_low;
  assign ack_n    = ~ack_on;
  assign drive_en = dir_read && ds_low && (st != XS_IDLE);

  // R4: a request lasts one clock and follows a data strobe fall
  a_r4_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> !reg_req);
  a_r4_req_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_req) |-> $past(ds_fall));
  // R6: acknowledge only after the register side reported ready
  a_r6_ack_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(acc_done) || $past(!ack_n));
  // R7: a rising data strobe ends the acknowledge
  a_r7_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    ds_rise |=> ack_n);
  // R8: the slave never drives the pins during a write
  a_r8_no_drive_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_wr |-> !drive_en);
endmodule

// File: rtl/strobe_bus_slave.sv
module strobe_bus_slave #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_as_n,
  input  logic              bus_ds_n,
  input  logic              bus_rnw,
  input  logic [ADDR_W-1:0] bus_addr,
  inout  wire  [DATA_W-1:0] bus_data,
  output logic              bus_ack_n,
  output logic              reg_req,
  output logic              reg_wr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_ready
);
  localparam int NSTROBE = 2;
  localparam int IDX_AS  = 0;
  localparam int IDX_DS  = 1;

  logic [NSTROBE-1:0] strobe_sync_n;
  logic [NSTROBE-1:0] strobe_fell;
  logic [NSTROBE-1:0] strobe_rose;
  logic [DATA_W-1:0]  rd_hold;
  logic               drive_en;

  sbs_strobe_sync #(.STAGES(SYNC_STAGES), .WIDTH(NSTROBE)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_n  ({bus_ds_n, bus_as_n}),
    .sync_n (strobe_sync_n),
    .fell   (strobe_fell),
    .rose   (strobe_rose)
  );

  sbs_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .as_open   (~strobe_sync_n[IDX_AS]),
    .as_close  (strobe_rose[IDX_AS]),
    .addr_pins (bus_addr),
    .addr_q    (reg_addr)
  );

  sbs_xfer_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ds_low     (~strobe_sync_n[IDX_DS]),
    .ds_fall    (strobe_fell[IDX_DS]),
    .ds_rise    (strobe_rose[IDX_DS]),
    .rnw_pin    (bus_rnw),
    .wdata_pins (bus_data),
    .reg_ready  (reg_ready),
    .reg_rdata  (reg_rdata),
    .reg_req    (reg_req),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .rd_hold    (rd_hold),
    .drive_en   (drive_en),
    .ack_n      (bus_ack_n)
  );

  assign bus_data = drive_en ? rd_hold : {DATA_W{1'bz}};

  // R1: no acknowledge and no request while the data strobe rests high
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_sync_n[IDX_DS] && $past(strobe_sync_n[IDX_DS])) |-> bus_ack_n);
  // R8: driving stops when the data strobe is back high
  a_r8_drive_stops: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_sync_n[IDX_DS] |-> !drive_en);
endmodule

// File: tb/test_strobe_bus_slave.sv
module test_strobe_bus_slave;
  localparam int AW = 15;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          as_n = 1'b1, ds_n = 1'b1, rnw = 1'b1;
  logic [AW-1:0] addr = '0;
  wire  [DW-1:0] bus_data;
  logic          tb_en = 1'b0;
  logic [DW-1:0] tb_val = '0;
  logic          ack_n, req, wr, ready;
  logic [AW-1:0] raddr;
  logic [DW-1:0] wdata, rdata;

  int total = 0, bad = 0;
  int cfg_delay = 0;
  logic pend_rdy = 1'b0, counting = 1'b0;
  int cnt = 0;
  int req_total = 0;
  logic [AW-1:0] cap_addr;
  logic          cap_wr;
  logic [DW-1:0] cap_wdata;

  always #2 clk = ~clk;

  assign bus_data = tb_en ? tb_val : {DW{1'bz}};

  function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
    return a[7:0] ^ {a[14:8], 1'b1} ^ 8'h3C;
  endfunction

  assign rdata = model_rd(raddr);
  assign ready = (cfg_delay == 0) ? req : pend_rdy;

  always @(posedge clk) begin
    pend_rdy <= 1'b0;
    if (req && cfg_delay != 0) begin
      cnt <= cfg_delay - 1; counting <= 1'b1;
    end else if (counting) begin
      if (cnt == 0) begin pend_rdy <= 1'b1; counting <= 1'b0; end
      else cnt <= cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (req) begin
      req_total = req_total + 1;
      cap_addr = raddr; cap_wr = wr; cap_wdata = wdata;
    end
  end

  strobe_bus_slave i_strobe_bus_slave (
    .clk(clk), .rst_n(rst_n), .bus_as_n(as_n), .bus_ds_n(ds_n),
    .bus_rnw(rnw), .bus_addr(addr), .bus_data(bus_data),
    .bus_ack_n(ack_n), .reg_req(req), .reg_wr(wr), .reg_addr(raddr),
    .reg_wdata(wdata), .reg_rdata(rdata), .reg_ready(ready)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive a probe and read it back: only equal if the slave is not driving
  task automatic probe_free(input string tag, input logic [DW-1:0] pv);
    tb_en = 1'b1; tb_val = pv;
    #0.5;
    chk(bus_data === pv, tag, int'(bus_data), int'(pv));
    tb_en = 1'b0;
  endtask

  task automatic xfer(input logic is_rd, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input int dly);
    int rdy_cyc, ack_cyc, cyc, n0, rel;
    logic [DW-1:0] exp_rd;
    exp_rd = model_rd(a);
    cfg_delay = dly;
    @(negedge clk);
    addr = a; as_n = 1'b0;
    waitn(4);
    as_n = 1'b1;
    waitn(4);
    addr = ~a;                       // R2: later pin changes must not matter
    rnw = is_rd;
    if (is_rd) probe_free("R8 free before strobe (read)", ~exp_rd);
    else begin tb_en = 1'b1; tb_val = d; end
    n0 = req_total;
    ds_n = 1'b0;
    rdy_cyc = -1; ack_cyc = -1; cyc = 0;
    while (ack_cyc < 0 && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (!ack_n) ack_cyc = cyc;
      else if (ready && rdy_cyc < 0) rdy_cyc = cyc;
    end
    chk(ack_cyc > 0, "R6 acknowledge arrives", ack_cyc, 1);
    chk(rdy_cyc >= 0 && ack_cyc == rdy_cyc + 1, "R6 ack one clock after ready",
        ack_cyc - rdy_cyc, 1);
    chk(req_total == n0 + 1, "R4 one request per strobe", req_total - n0, 1);
    chk(cap_addr == a, "R2 latched address", int'(cap_addr), int'(a));
    chk(cap_wr == !is_rd, "R3 direction", int'(cap_wr), int'(!is_rd));
    if (is_rd)
      chk(bus_data === exp_rd, "R8 read data on pins", int'(bus_data), int'(exp_rd));
    else begin
      chk(cap_wdata == d, "R5 write data", int'(cap_wdata), int'(d));
      chk(bus_data === d, "R8 no drive during write", int'(bus_data), int'(d));
    end
    ds_n = 1'b1;
    rel = 0;
    while (!ack_n && rel < 20) begin @(negedge clk); rel++; end
    chk(rel <= 3, "R7 ack release", rel, 3);
    tb_en = 1'b0;
    waitn(4);
    probe_free("R8 free after strobe", ~exp_rd);
    chk(ack_n == 1'b1, "R7 ack stays high", int'(ack_n), 1);
    chk(req_total == n0 + 1, "R4 no extra request", req_total - n0, 1);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h0000_5EED);
    waitn(3);
    chk(ack_n == 1'b1, "R1 ack high in reset", int'(ack_n), 1);
    chk(req == 1'b0, "R1 no request in reset", int'(req), 0);
    probe_free("R1 pins free in reset", 8'h5A);
    rst_n = 1'b1;
    waitn(3);
    chk(ack_n == 1'b1, "R1 ack high after reset", int'(ack_n), 1);
    probe_free("R1 pins free after reset", 8'hA5);
    chk(req_total == 0, "R1 no request after reset", req_total, 0);

    xfer(1'b0, 15'h0000, 8'hFF, 0);   // zero-wait write, low corner
    xfer(1'b1, 15'h7FFF, 8'h00, 0);   // zero-wait read, high corner
    xfer(1'b1, 15'h1234, 8'h00, 40);  // long stretched read
    xfer(1'b0, 15'h4321, 8'h81, 40);  // long stretched write
    for (int k = 0; k < 30; k++) begin
      logic [AW-1:0] ra;
      logic [DW-1:0] rd8;
      ra  = AW'($urandom);
      rd8 = DW'($urandom);
      xfer(1'($urandom), ra, rd8, int'($urandom % 7));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule